// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each slot holds a virtual page number, the physical frame it maps to, and the identifier of the address space (process) that owns it, plus a valid flag. A lookup presents a page number together with the identifier of the running process. The search runs over all slots at once. One cycle later the block reports either a hit, with the frame number, or a miss. On a miss the surrounding logic walks the page table and writes the result back through the refill inputs.

The refill path picks its slot in a fixed order. A slot already holding the same page and identifier is written over. Failing that, the lowest-numbered empty slot is used. When every slot is full, the least recently used one is evicted. A hit and a refill both count as a use. Two flush inputs invalidate either every slot or only the slots of one address space, so that stale mappings can be removed when a page table changes.

The response logic is a three-state machine. Its states are RSP_IDLE (no request last cycle), RSP_HIT and RSP_MISS. From any state it moves to RSP_HIT when a request matches, to RSP_MISS when a request finds no match, and to RSP_IDLE when there is no request.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid, rsp_hit and rsp_miss are low and rsp_pfn is zero. Every lookup made before any refill misses.
- R2: A lookup presented with lk_valid high in one cycle produces its result in the next cycle, with exactly one of rsp_hit and rsp_miss high. A cycle without a lookup is followed by a cycle with both low.
- R3: A lookup hits only when some slot is valid, its page number equals lk_vpn and its identifier equals lk_asid. rsp_pfn then carries that slot's frame number.
- R4: A lookup whose page matches only slots with a different identifier misses. On a miss rsp_pfn is zero.
- R5: A lookup and a refill of the same page and identifier in the same cycle give a miss. A lookup of that page in the following cycle hits.
- R6: A refill that matches no existing slot goes into the lowest-numbered invalid slot whenever one exists.
- R7: When all slots are valid, a refill that matches no slot replaces the slot whose last use (hit or refill) is oldest.
- R8: A refill whose page and identifier equal those of a valid slot overwrites that slot's frame number and evicts nothing.
- R9: flush_all invalidates every slot. Lookups from the next cycle on miss.
- R10: flush_asid_valid invalidates only the slots whose identifier equals flush_asid. All other slots keep their state.
- R11: A refill in the same cycle as either flush is dropped. A lookup in the same cycle as a flush sees the contents from before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Identifier of the running process |
| rsp_hit | output | 1 | Registered: previous lookup hit |
| rsp_miss | output | 1 | Registered: previous lookup missed |
| rsp_pfn | output | PFN_W | Registered frame number on hit, zero otherwise |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_pfn | input | PFN_W | Frame number to install |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_valid | input | 1 | Invalidate the slots of one identifier |
| flush_asid | input | ASID_W | Identifier to invalidate |

## Verification
The hardest condition to reach from the ports is a full cache whose recency order differs from its fill order. Only then does replacement pick a slot that is neither the first nor the last one filled. The stimulus fills all slots, then touches a chosen subset with hits, then refills new pages and looks up every old page to see which one went. A long random phase follows. It uses a narrow range of pages and identifiers so that duplicate refills, partial flushes and evictions collide often. It is compared every cycle against a recency list kept in the bench as a queue.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Response state: what the previous cycle's lookup produced
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [N-1:0][ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]         q_vpn,
    input  logic [ASID_W-1:0]        q_asid,
    output logic [N-1:0]             hit_vec,
    output logic [IDX_W-1:0]         hit_idx,
    output logic                     any_hit
);

    // One comparator per slot: valid, page and identifier must all agree
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign hit_vec[g] = ent_valid[g]
                              && (ent_vpn[g] == q_vpn)
                              && (ent_asid[g] == q_asid);
        end
    endgenerate

    assign any_hit = |hit_vec;

    // Encoder; at most one bit is set, lowest index wins otherwise
    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] lru_idx
);

    // Each slot carries an age; ages always form a permutation of 0..N-1.
    // Age 0 is the most recent use, age N-1 the oldest.
    logic [N-1:0][IDX_W-1:0] age_q;
    logic [N-1:0][IDX_W-1:0] age_d;
    logic [IDX_W-1:0]        ref_age;

    assign ref_age = age_q[touch_idx];

    always_comb begin
        age_d = age_q;
        if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_d[i] = '0;
                else if (age_q[i] < ref_age)
                    age_d[i] = age_q[i] + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
        end else begin
            age_q <= age_d;
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (age_q[i] == IDX_W'(N - 1)) lru_idx = IDX_W'(i);
        end
    end

    // Ages stay distinct
    logic [N-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int i = 0; i < N; i++) begin
            if (int'(age_q[i]) < N) age_seen[age_q[i]] = 1'b1;
        end
    end

    p_age_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(age_seen) == N);

    // A slot just used is never the next eviction choice
    p_touch_not_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (lru_idx != $past(touch_idx)));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     ent_valid,
    input  logic             dup_any,
    input  logic [IDX_W-1:0] dup_idx,
    input  logic [IDX_W-1:0] lru_idx,
    output logic [IDX_W-1:0] victim_idx
);

    logic             have_free;
    logic [IDX_W-1:0] free_idx;

    assign have_free = ~&ent_valid;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_idx = IDX_W'(i);
        end
    end

    // Same mapping first, then an empty slot, then the oldest slot
    always_comb begin
        if (dup_any)        victim_idx = dup_idx;
        else if (have_free) victim_idx = free_idx;
        else                victim_idx = lru_idx;
    end

    p_free_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dup_any && have_free) |-> !ent_valid[victim_idx]);

    p_dup_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dup_any |-> ent_valid[victim_idx]);

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [PFN_W-1:0]  rsp_pfn,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              flush_all,
    input  logic              flush_asid_valid,
    input  logic [ASID_W-1:0] flush_asid
);
    import tlb_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Slot storage
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;

    // Lookup search
    logic [ENTRIES-1:0] lk_hit_vec;
    logic [IDX_W-1:0]   lk_hit_idx;
    logic               lk_any;

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_lk_cam (
        .ent_valid (valid_q),
        .ent_vpn   (vpn_q),
        .ent_asid  (asid_q),
        .q_vpn     (lk_vpn),
        .q_asid    (lk_asid),
        .hit_vec   (lk_hit_vec),
        .hit_idx   (lk_hit_idx),
        .any_hit   (lk_any)
    );

    // Refill search for an existing copy of the same mapping
    logic [ENTRIES-1:0] dup_vec;
    logic [IDX_W-1:0]   dup_idx;
    logic               dup_any;

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_fill_cam (
        .ent_valid (valid_q),
        .ent_vpn   (vpn_q),
        .ent_asid  (asid_q),
        .q_vpn     (fill_vpn),
        .q_asid    (fill_asid),
        .hit_vec   (dup_vec),
        .hit_idx   (dup_idx),
        .any_hit   (dup_any)
    );

    // Replacement
    logic             fill_acc;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;
    logic [IDX_W-1:0] lru_idx;
    logic [IDX_W-1:0] victim_idx;

    assign fill_acc  = fill_valid && !flush_all && !flush_asid_valid;
    assign touch_en  = fill_acc || (lk_valid && lk_any);
    assign touch_idx = fill_acc ? victim_idx : lk_hit_idx;

    tlb_lru #(.N(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_valid  (valid_q),
        .dup_any    (dup_any),
        .dup_idx    (dup_idx),
        .lru_idx    (lru_idx),
        .victim_idx (victim_idx)
    );

    // Selective flush match
    logic [ENTRIES-1:0] kill_vec;
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_kill
            assign kill_vec[g] = (asid_q[g] == flush_asid);
        end
    endgenerate

    // Slot update: flushes take precedence and drop a concurrent refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            vpn_q   <= '0;
            asid_q  <= '0;
            pfn_q   <= '0;
        end else if (flush_all) begin
            valid_q <= '0;
        end else if (flush_asid_valid) begin
            valid_q <= valid_q & ~kill_vec;
        end else if (fill_valid) begin
            valid_q[victim_idx] <= 1'b1;
            vpn_q[victim_idx]   <= fill_vpn;
            asid_q[victim_idx]  <= fill_asid;
            pfn_q[victim_idx]   <= fill_pfn;
        end
    end

    // Response state machine: state register
    rsp_state_e       rsp_state_q;
    rsp_state_e       rsp_state_d;
    logic [PFN_W-1:0] rsp_pfn_q;

    always_comb begin
        rsp_state_d = RSP_IDLE;
        if (lk_valid) rsp_state_d = lk_any ? RSP_HIT : RSP_MISS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_state_q <= RSP_IDLE;
            rsp_pfn_q   <= '0;
        end else begin
            rsp_state_q <= rsp_state_d;
            rsp_pfn_q   <= (lk_valid && lk_any) ? pfn_q[lk_hit_idx] : '0;
        end
    end

    // Response state machine: outputs
    always_comb begin
        rsp_hit  = 1'b0;
        rsp_miss = 1'b0;
        unique case (rsp_state_q)
            RSP_IDLE: ;
            RSP_HIT:  rsp_hit  = 1'b1;
            RSP_MISS: rsp_miss = 1'b1;
            default:  ;
        endcase
    end

    assign rsp_pfn = rsp_pfn_q;

    // Assertions
    p_req_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_hit ^ rsp_miss));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_hit && !rsp_miss));

    p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_pfn == '0));

    p_single_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));

    p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_acc |=> valid_q[$past(victim_idx)]);

    p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

    p_flush_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_asid_valid && !flush_all) |=> (valid_q == $past(valid_q & ~kill_vec)));

    p_flush_drops_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && (flush_all || flush_asid_valid)) |=> ($stable(vpn_q) && $stable(pfn_q)));

endmodule

// File: tb/asid_tlb_test.sv
module asid_tlb_test;

    localparam int N      = 8;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 16;
    localparam int ASID_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              rsp_hit;
    logic              rsp_miss;
    logic [PFN_W-1:0]  rsp_pfn;
    logic              fill_valid = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PFN_W-1:0]  fill_pfn = '0;
    logic              flush_all = 1'b0;
    logic              flush_asid_valid = 1'b0;
    logic [ASID_W-1:0] flush_asid = '0;

    always #10 clk = ~clk;

    asid_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pfn(rsp_pfn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
        .flush_all(flush_all), .flush_asid_valid(flush_asid_valid), .flush_asid(flush_asid)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    started = 0;
    string cur_req = "R1";

    // Behavioural reference: slot contents plus a recency list (front = newest)
    bit               m_v   [N];
    logic [VPN_W-1:0] m_vpn [N];
    logic [ASID_W-1:0] m_asid[N];
    logic [PFN_W-1:0] m_pfn [N];
    int               order[$];
    bit               e_hit, e_miss;
    logic [PFN_W-1:0] e_pfn;
    int               h, v;
    bit               facc;

    function automatic int find(logic [VPN_W-1:0] pv, logic [ASID_W-1:0] pa);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == pv && m_asid[i] == pa) return i;
        return -1;
    endfunction

    task automatic touch(int idx);
        for (int k = 0; k < order.size(); k++)
            if (order[k] == idx) begin order.delete(k); break; end
        order.push_front(idx);
    endtask

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            order.delete();
            for (int i = 0; i < N; i++) order.push_back(i);
            e_hit = 0; e_miss = 0; e_pfn = '0;
        end else begin
            h = lk_valid ? find(lk_vpn, lk_asid) : -1;
            e_hit  = lk_valid && (h >= 0);
            e_miss = lk_valid && (h < 0);
            e_pfn  = e_hit ? m_pfn[h] : '0;
            facc = 0;
            if (flush_all) begin
                for (int i = 0; i < N; i++) m_v[i] = 0;
            end else if (flush_asid_valid) begin
                for (int i = 0; i < N; i++) if (m_asid[i] == flush_asid) m_v[i] = 0;
            end else if (fill_valid) begin
                facc = 1;
                v = find(fill_vpn, fill_asid);
                if (v < 0)
                    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) v = i;
                if (v < 0) v = order[order.size() - 1];
                m_v[v] = 1; m_vpn[v] = fill_vpn; m_asid[v] = fill_asid; m_pfn[v] = fill_pfn;
                touch(v);
            end
            if (!facc && h >= 0) touch(h);
        end
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual cyc=%0d expected below 150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            total++;
            if (rsp_hit !== e_hit || rsp_miss !== e_miss || rsp_pfn !== e_pfn) begin
                bad++;
                $display("FAIL %s: actual hit=%0b miss=%0b pfn=%h expected hit=%0b miss=%0b pfn=%h",
                         cur_req, rsp_hit, rsp_miss, rsp_pfn, e_hit, e_miss, e_pfn);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; flush_all = 0; flush_asid_valid = 0;
    endtask

    task automatic lookup(logic [VPN_W-1:0] pv, logic [ASID_W-1:0] pa);
        lk_valid = 1; lk_vpn = pv; lk_asid = pa;
        tick();
    endtask

    task automatic fill(logic [VPN_W-1:0] pv, logic [ASID_W-1:0] pa, logic [PFN_W-1:0] pf);
        fill_valid = 1; fill_vpn = pv; fill_asid = pa; fill_pfn = pf;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state and empty-cache misses
        cur_req = "R1";
        tick();
        lookup(20'h00100, 8'd1);
        lookup(20'h00000, 8'd0);
        // R6: fill from empty, lowest free slot first
        cur_req = "R6";
        for (int i = 0; i < N; i++) fill(20'h00100 + i, 8'd1, 16'h0200 + i);
        // R3: every installed page hits with its frame
        cur_req = "R3";
        for (int i = 0; i < N; i++) lookup(20'h00100 + i, 8'd1);
        // R4: same page, other process
        cur_req = "R4";
        lookup(20'h00103, 8'd2);
        lookup(20'h00999, 8'd1);
        // R2: gaps between requests
        cur_req = "R2";
        tick(); lookup(20'h00101, 8'd1); tick(); tick();
        // R7: touch a subset, then replace
        cur_req = "R7";
        lookup(20'h00100, 8'd1); lookup(20'h00102, 8'd1); lookup(20'h00105, 8'd1);
        fill(20'h00300, 8'd1, 16'h0300);
        fill(20'h00301, 8'd1, 16'h0301);
        for (int i = 0; i < N; i++) lookup(20'h00100 + i, 8'd1);
        lookup(20'h00300, 8'd1); lookup(20'h00301, 8'd1);
        // R5: refill and lookup of the same page in one cycle
        cur_req = "R5";
        fill_valid = 1; fill_vpn = 20'h00400; fill_asid = 8'd1; fill_pfn = 16'h0400;
        lk_valid = 1; lk_vpn = 20'h00400; lk_asid = 8'd1;
        tick();
        lookup(20'h00400, 8'd1);
        // R8: refill of an existing mapping overwrites in place
        cur_req = "R8";
        fill(20'h00400, 8'd1, 16'h0abc);
        lookup(20'h00400, 8'd1);
        for (int i = 0; i < N; i++) lookup(20'h00100 + i, 8'd1);
        lookup(20'h00300, 8'd1); lookup(20'h00301, 8'd1);
        // R10: flush one process only
        cur_req = "R10";
        fill(20'h00500, 8'd3, 16'h0500);
        fill(20'h00501, 8'd3, 16'h0501);
        flush_asid_valid = 1; flush_asid = 8'd3;
        tick();
        lookup(20'h00500, 8'd3); lookup(20'h00501, 8'd3);
        for (int i = 0; i < N; i++) lookup(20'h00100 + i, 8'd1);
        lookup(20'h00400, 8'd1);
        // R11: flush beats refill; lookup sees old contents
        cur_req = "R11";
        fill_valid = 1; fill_vpn = 20'h00600; fill_asid = 8'd1; fill_pfn = 16'h0600;
        flush_asid_valid = 1; flush_asid = 8'd7;
        lk_valid = 1; lk_vpn = 20'h00400; lk_asid = 8'd1;
        tick();
        lookup(20'h00600, 8'd1);
        // R9: flush everything
        cur_req = "R9";
        flush_all = 1; lk_valid = 1; lk_vpn = 20'h00400; lk_asid = 8'd1;
        fill_valid = 1; fill_vpn = 20'h00700; fill_asid = 8'd1; fill_pfn = 16'h0700;
        tick();
        lookup(20'h00400, 8'd1); lookup(20'h00700, 8'd1);
        // R3: random mix over a narrow space
        cur_req = "R3";
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            lk_valid = ($urandom_range(0, 3) != 0);
            lk_vpn = 20'h00010 + 20'($urandom_range(0, 11));
            lk_asid = 8'($urandom_range(0, 2));
            if (r < 40) begin
                fill_valid = 1;
                fill_vpn = 20'h00010 + 20'($urandom_range(0, 11));
                fill_asid = 8'($urandom_range(0, 2));
                fill_pfn = 16'($urandom);
            end
            if (r >= 40 && r < 43) begin
                flush_asid_valid = 1; flush_asid = 8'($urandom_range(0, 2));
            end
            if (r == 43) flush_all = 1;
            tick();
        end
        tick();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule